// File: doc/BRIEF.md
# Strobe-Latched Single-Bit Static Memory

This block is a 4096 x 1 static memory whose accesses are framed by an active-low strobe, `cs_n`. It is modelled inside a synchronous fabric: the strobe, the write-enable level, the address and the data input are all sampled on the rising edge of `clk`. A strobe falling edge starts an access. On that edge the block captures the address and decides whether the data output may drive during the access. The strobe returning high ends the access.

The level of `wr_n` on the starting edge chooses the output mode for the whole access. If `wr_n` is low, the access is an early write and the output stays released for the entire access. If `wr_n` is high, the stored bit appears on `q` a fixed number of clocks later, and `q_drv` marks when it is valid. A write can still follow inside the same access; this gives the late-write and read-modify-write forms.

The data and strobe pins are plain level controls. The access protocol has no valid/ready handshake and no back-pressure: the caller owns the timing of each access.

Top module: `edge_latched_sram`

## Requirements
- R1: The address is taken from `addr` on the clock where `cs_n` is first seen low after being high. Later changes to `addr` during that access have no effect on which bit is read or written.
- R2: If `wr_n` is low on the starting clock, `q_drv` stays 0 for the whole access (early write).
- R3: If `wr_n` is high on the starting clock, `q_drv` rises exactly `ACC_CLKS` clocks after the starting clock (default 2). At that point `q` carries the bit stored at the latched address.
- R4: Once `q_drv` is 1, `q` and `q_drv` hold steady until the access ends, even if a write to the same bit happens during the access. A read-modify-write therefore shows the old bit.
- R5: Each stretch of `wr_n` low inside an access commits exactly one write to the latched address. The written value is `din` as sampled on the first clock where `wr_n` is seen high again, or where `cs_n` is seen high, whichever comes first.
- R6: On the first clock where `cs_n` is seen high, the access ends and `q_drv` falls. A new access needs a fresh high-to-low strobe transition.
- R7: `q` is 0 whenever `q_drv` is 0 (the released output is modelled as 0).
- R8: Stored bits are kept unchanged for any length of idle time.
- R9: During and after reset, with no access started, `q_drv` and `q` are 0.
- R10: Back-to-back accesses choose their output modes independently; an early write does not stop the next read from driving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low access strobe |
| wr_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Bit address, captured at the start of an access |
| din | input | 1 | Write data |
| q | output | 1 | Read data; 0 while released |
| q_drv | output | 1 | Output driving and read data valid |

## Verification
A wrong address latch shows up as a read of the wrong bit. The bench moves `addr` on the clock after each access starts, so this appears at the very next data-valid point. A wrong mode latch shows as `q_drv` rising during an early write, or staying low during a read, within `ACC_CLKS` clocks of the start. A wrong commit point or wrong commit data stays hidden until that bit is read back in a later access. The reference model tracks every written bit, so the fault is reported on the first such read.

// File: rtl/esram_pkg.sv
package esram_pkg;
  // Output mode chosen on the starting clock of an access
  typedef enum logic {
    MODE_RELEASED = 1'b0,
    MODE_DRIVE    = 1'b1
  } out_mode_e;
endpackage

// File: rtl/esram_strobe_edge.sv
module esram_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  output logic start_o
);
  logic cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= cs_n_i;
  end

  assign start_o = cs_n_q & ~cs_n_i;

  // R6
  start_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

// File: rtl/esram_cycle_ctrl.sv
module esram_cycle_ctrl
  import esram_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ACC_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cs_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_lat_o,
  output logic              drv_o
);
  localparam int CW = $clog2(ACC_CLKS + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(ACC_CLKS);

  out_mode_e      mode_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o   <= 1'b0;
      addr_lat_o <= '0;
      mode_q     <= MODE_RELEASED;
      cnt_q      <= '0;
    end else if (start_i) begin
      active_o   <= 1'b1;
      addr_lat_o <= addr_i;
      mode_q     <= wr_n_i ? MODE_DRIVE : MODE_RELEASED;
      cnt_q      <= '0;
    end else if (active_o && cs_n_i) begin
      active_o   <= 1'b0;
      mode_q     <= MODE_RELEASED;
      cnt_q      <= '0;
    end else if (active_o && cnt_q != CNT_TOP) begin
      cnt_q      <= cnt_q + 1'b1;
    end
  end

  assign drv_o = active_o && (mode_q == MODE_DRIVE) && (cnt_q == CNT_TOP);

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i) |=> $stable(addr_lat_o));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !cs_n_i) |=> $stable(mode_q));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
endmodule

// File: rtl/esram_wr_commit.sv
module esram_wr_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  input  logic cs_n_i,
  input  logic wr_n_i,
  output logic fire_o
);
  logic pend_q;

  assign fire_o = active_i && pend_q && (wr_n_i || cs_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (start_i)          pend_q <= ~wr_n_i;
    else if (!active_i)        pend_q <= 1'b0;
    else if (fire_o || cs_n_i) pend_q <= 1'b0;
    else if (!wr_n_i)          pend_q <= 1'b1;
  end

  // R5
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/esram_bit_array.sv
module esram_bit_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              active_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wd_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rd_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wd_i;
    if (re_i) rd_o <= mem_q[raddr_i];
  end

  // R5
  write_in_access_chk: assert property (@(posedge clk)
    we_i |-> (active_i && !re_i));
endmodule

// File: rtl/edge_latched_sram.sv
module edge_latched_sram #(
  parameter int ADDR_W   = 12,
  parameter int ACC_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              q,
  output logic              q_drv
);
  logic              start;
  logic              active;
  logic [ADDR_W-1:0] addr_lat;
  logic              fire;
  logic              rd_bit;

  esram_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .start_o(start)
  );

  esram_cycle_ctrl #(.ADDR_W(ADDR_W), .ACC_CLKS(ACC_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cs_n_i(cs_n),
    .wr_n_i(wr_n), .addr_i(addr), .active_o(active),
    .addr_lat_o(addr_lat), .drv_o(q_drv)
  );

  esram_wr_commit u_wr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .active_i(active),
    .cs_n_i(cs_n), .wr_n_i(wr_n), .fire_o(fire)
  );

  esram_bit_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .active_i(active), .we_i(fire), .waddr_i(addr_lat),
    .wd_i(din), .re_i(start), .raddr_i(addr), .rd_o(rd_bit)
  );

  assign q = q_drv ? rd_bit : 1'b0;

  // R4
  q_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_drv && !cs_n) |=> (q_drv && $stable(q)));

  // R6
  drop_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_drv) |-> $past(cs_n));
endmodule

// File: tb/sim_edge_latched_sram.sv
module sim_edge_latched_sram;
  localparam int AW  = 12;
  localparam int ACC = 2;
  localparam int DEPTH = 1 << AW;
  localparam int K_READ = 0, K_EARLY = 1, K_LATE = 2, K_RMW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic q, q_drv;

  int checks = 0, fails = 0;
  bit done = 0;
  logic model [DEPTH];
  bit   known [DEPTH];

  always #2.5 clk = ~clk;

  edge_latched_sram #(.ADDR_W(AW), .ACC_CLKS(ACC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .din(din), .q(q), .q_drv(q_drv)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] pool_addr(int i);
    return AW'((i * 613 + 5) % DEPTH);
  endfunction

  // One complete access of the given kind; the address is scrambled after latching (R1)
  task automatic access(int kind, logic [AW-1:0] a, logic d);
    logic old_bit;
    bit   old_ok;
    old_bit = model[a];
    old_ok  = known[a];
    cs_n = 1'b0; addr = a; din = d; wr_n = (kind == K_EARLY) ? 1'b0 : 1'b1;
    tick();
    addr = a ^ {AW{1'b1}};
    if (kind != K_EARLY) din = ~d;
    chk("R3 no early drive", q_drv, 1'b0);
    for (int i = 1; i < ACC; i++) begin
      tick();
      chk("R3 no early drive", q_drv, 1'b0);
    end
    tick();
    if (kind == K_EARLY) begin
      chk("R2 early write released", q_drv, 1'b0);
      chk("R7 released q", q, 1'b0);
    end else begin
      chk("R3 drive at access time", q_drv, 1'b1);
      if (old_ok) chk("R1 R3 read data", q, old_bit);
    end
    case (kind)
      K_RMW: begin
        wr_n = 1'b0; din = d; tick();
        wr_n = 1'b1; tick();
        din = ~d;
        chk("R4 RMW keeps drive", q_drv, 1'b1);
        if (old_ok) chk("R4 RMW old data", q, old_bit);
      end
      K_LATE: begin
        wr_n = 1'b0; din = d; tick();
        chk("R4 late write keeps drive", q_drv, 1'b1);
        if (old_ok) chk("R4 late write old data", q, old_bit);
      end
      K_EARLY: begin
        tick();
        chk("R2 early write released", q_drv, 1'b0);
      end
      default: tick();
    endcase
    cs_n = 1'b1;
    tick();
    wr_n = 1'b1;
    din = 1'b0;
    chk("R6 end releases", q_drv, 1'b0);
    chk("R7 released q", q, 1'b0);
    if (kind != K_READ) begin
      model[a] = d;
      known[a] = 1'b1;
    end
  endtask

  task automatic read_expect(logic [AW-1:0] a, logic exp, string req);
    cs_n = 1'b0; wr_n = 1'b1; addr = a;
    tick();
    addr = a + 1'b1;
    for (int i = 0; i < ACC; i++) tick();
    chk(req, q_drv, 1'b1);
    chk(req, q, exp);
    cs_n = 1'b1;
    tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      known[i] = 1'b0;
      model[i] = 1'b0;
    end
    tick();
    chk("R9 reset drive", q_drv, 1'b0);
    chk("R9 reset q", q, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R9 idle after reset", q_drv, 1'b0);

    // Directed: fill the pool by early writes (R2, R5)
    for (int i = 0; i < 16; i++) access(K_EARLY, pool_addr(i), logic'(i[0]));
    // Early write followed at once by a read (R10)
    access(K_EARLY, pool_addr(3), 1'b0);
    access(K_READ,  pool_addr(3), 1'b1);
    // RMW twice on the same bit (R4, R5)
    access(K_RMW, pool_addr(4), 1'b1);
    access(K_RMW, pool_addr(4), 1'b0);
    read_expect(pool_addr(4), 1'b0, "R5 RMW stored");
    // Late write committed at the end of the access (R5)
    access(K_LATE, pool_addr(5), 1'b1);
    read_expect(pool_addr(5), 1'b1, "R5 late stored");
    // Strobe held low: no second access starts (R6)
    cs_n = 1'b0; wr_n = 1'b1; addr = pool_addr(6);
    for (int i = 0; i < ACC + 4; i++) tick();
    chk("R6 held strobe drives once", q_drv, 1'b1);
    cs_n = 1'b1; tick();
    // Retention across idle time (R8)
    for (int i = 0; i < 60; i++) tick();
    read_expect(pool_addr(0), model[pool_addr(0)], "R8 retention");
    read_expect(pool_addr(1), model[pool_addr(1)], "R8 retention");

    // Random mix of access kinds on the pool (R1..R7, R10)
    for (int n = 0; n < 300; n++) begin
      int k;
      k = $urandom_range(0, 3);
      access(k, pool_addr($urandom_range(0, 15)), logic'($urandom_range(0, 1)));
      for (int j = $urandom_range(0, 2); j > 0; j--) tick();
    end
    for (int i = 0; i < 16; i++)
      read_expect(pool_addr(i), model[pool_addr(i)], "R5 final contents");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule